// File: doc/BRIEF.md
# DRAM Clock-Enable Power State Tracker

This block follows the power state of a graphics DRAM by watching the clock-enable pin on every clock edge. It keeps the level seen on the previous edge in a flop, and uses that level together with the current level, the command issued on the current edge and a flag that says whether every bank is idle. The result is one of five states: Idle, Active, Precharge Power Down, Active Power Down or Self Refresh.

Any mix of state, clock-enable pair and command that the transition rules do not allow raises an illegal flag for one cycle, and the state stays where it was. When the device leaves Self Refresh, a recovery window opens. The window covers a fixed number of clock edges (200 by default). Any command other than NOP or DESEL issued inside that window raises a violation flag.

Bank open and close tracking is done elsewhere and arrives through `banks_idle`. Refresh interval timing is not part of this block. All outputs are registered, so the response to the inputs sampled at edge n appears just after edge n.

Top module: `cke_power_tracker`

## Requirements
- R1: During and right after reset, `pwr_state` is Idle, and `illegal`, `in_recovery` and `recovery_viol` are all 0. The previous clock-enable sample is taken as high. State codes are Idle=0, Active=1, Precharge Power Down=2, Active Power Down=3 and Self Refresh=4.
- R2: If clock-enable is low on both the previous and the current edge while in state 2, 3 or 4, the state is kept and no illegal flag is raised, whatever the command. Command codes are NOP=0, DESEL=1, ACT=2, READ=3, WRITE=4, PRE=5, AREF=6 and MRS=7.
- R3: If clock-enable goes from low to high with NOP or DESEL, the state moves from Precharge Power Down to Idle, from Active Power Down to Active, and from Self Refresh to Idle.
- R4: If clock-enable goes from high to low with NOP or DESEL while in Idle or Active, the state moves to Precharge Power Down when `banks_idle`=1, and to Active Power Down when `banks_idle`=0.
- R5: If clock-enable goes from high to low with AREF (code 6) while in Idle or Active and `banks_idle`=1, the state moves to Self Refresh.
- R6: If clock-enable is high on both edges while in Idle or Active, the next state is Idle when `banks_idle`=1 and Active otherwise. No illegal flag is raised for any command.
- R7: Every other combination raises `illegal` for exactly one cycle, and `pwr_state` keeps its value.
- R8: The edge that leaves Self Refresh loads a window of XSR_CYCLES edges. `in_recovery` is high from just after the exit edge until XSR_CYCLES further edges have passed. A later exit from Self Refresh reloads the window.
- R9: A command other than NOP or DESEL on an edge inside the recovery window raises `recovery_viol` for one cycle. The window keeps counting down regardless.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock-enable level sampled on this edge |
| cmd | input | 3 | Command registered on this edge (codes in R2) |
| banks_idle | input | 1 | High when no bank is open |
| pwr_state | output | 3 | Current power state (codes in R1) |
| illegal | output | 1 | One-cycle pulse for a disallowed transition |
| in_recovery | output | 1 | High while the post-self-refresh window is open |
| recovery_viol | output | 1 | One-cycle pulse for a non-quiet command inside the window |

## Verification
Two functions can act on the same edge: the transition decode and the recovery-window check. Both judge the same command. The bench leaves Self Refresh and then, inside the window, drops clock-enable once with AREF and banks idle. That is a legal entry into Self Refresh, but it is also a window violation. It also drops clock-enable once with READ, which is an illegal transition and a window violation at the same time. A behavioural model predicts all four outputs on every clock, so both flags and the state are judged together on those cycles.

// File: rtl/cke_trk_pkg.sv
package cke_trk_pkg;

  localparam int CMD_W   = 3;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    PS_IDLE     = 3'd0,
    PS_ACTIVE   = 3'd1,
    PS_PRE_PD   = 3'd2,
    PS_ACT_PD   = 3'd3,
    PS_SELF_REF = 3'd4
  } pwr_state_e;

  typedef enum logic [CMD_W-1:0] {
    CM_NOP   = 3'd0,
    CM_DESEL = 3'd1,
    CM_ACT   = 3'd2,
    CM_READ  = 3'd3,
    CM_WRITE = 3'd4,
    CM_PRE   = 3'd5,
    CM_AREF  = 3'd6,
    CM_MRS   = 3'd7
  } cmd_e;

  // {previous sample, current sample}
  typedef enum logic [1:0] {
    CK_LL = 2'b00,
    CK_LH = 2'b01,
    CK_HL = 2'b10,
    CK_HH = 2'b11
  } cke_edge_e;

  typedef struct packed {
    pwr_state_e next;
    logic       bad;
    logic       sref_exit;
  } step_t;

  function automatic logic is_quiet(cmd_e c);
    return (c == CM_NOP) || (c == CM_DESEL);
  endfunction

  function automatic logic is_low_power(pwr_state_e s);
    return (s == PS_PRE_PD) || (s == PS_ACT_PD) || (s == PS_SELF_REF);
  endfunction

endpackage

// File: rtl/cke_edge_sampler.sv
module cke_edge_sampler #(
  parameter bit RESET_LEVEL = 1'b1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cke,
  output cke_trk_pkg::cke_edge_e edge_kind
);
  logic cke_prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) cke_prev_q <= RESET_LEVEL;
    else        cke_prev_q <= cke;
  end

  assign edge_kind = cke_trk_pkg::cke_edge_e'({cke_prev_q, cke});
endmodule

// File: rtl/pwr_step_decode.sv
module pwr_step_decode
  import cke_trk_pkg::*;
(
  input  pwr_state_e cur,
  input  cke_edge_e  edge_kind,
  input  cmd_e       cmd,
  input  logic       banks_idle,
  output step_t      step
);
  logic quiet;
  logic low_pwr;

  assign quiet   = is_quiet(cmd);
  assign low_pwr = is_low_power(cur);

  always_comb begin
    step.next      = cur;
    step.bad       = 1'b0;
    step.sref_exit = 1'b0;
    unique case (edge_kind)
      CK_LL: begin
        // low power states hold for any command
        if (!low_pwr) step.bad = 1'b1;
      end
      CK_LH: begin
        if (!low_pwr || !quiet) begin
          step.bad = 1'b1;
        end else begin
          case (cur)
            PS_ACT_PD:   step.next = PS_ACTIVE;
            PS_SELF_REF: begin
              step.next      = PS_IDLE;
              step.sref_exit = 1'b1;
            end
            default:     step.next = PS_IDLE;
          endcase
        end
      end
      CK_HL: begin
        if (low_pwr) begin
          step.bad = 1'b1;
        end else if (quiet) begin
          step.next = banks_idle ? PS_PRE_PD : PS_ACT_PD;
        end else if ((cmd == CM_AREF) && banks_idle) begin
          step.next = PS_SELF_REF;
        end else begin
          step.bad = 1'b1;
        end
      end
      CK_HH: begin
        if (low_pwr) step.bad = 1'b1;
        else         step.next = banks_idle ? PS_IDLE : PS_ACTIVE;
      end
      default: step.bad = 1'b1;
    endcase
  end
endmodule

// File: rtl/pwr_state_reg.sv
module pwr_state_reg
  import cke_trk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  step_t      step,
  output pwr_state_e state_q,
  output logic       illegal_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= PS_IDLE;
      illegal_q <= 1'b0;
    end else begin
      state_q   <= step.next;
      illegal_q <= step.bad;
    end
  end
endmodule

// File: rtl/xsr_quiet_window.sv
module xsr_quiet_window
  import cke_trk_pkg::*;
#(
  parameter int unsigned XSR_CYCLES = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  cmd_e cmd,
  output logic active,
  output logic viol
);
  localparam int CNT_W = $clog2(XSR_CYCLES + 1);
  localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(XSR_CYCLES);

  logic [CNT_W-1:0] remain_q;

  assign active = (remain_q != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remain_q <= '0;
      viol     <= 1'b0;
    end else begin
      viol <= active && !is_quiet(cmd);
      if (start)       remain_q <= LOAD_VAL;
      else if (active) remain_q <= remain_q - 1'b1;
    end
  end
endmodule

// File: rtl/cke_power_tracker.sv
module cke_power_tracker
  import cke_trk_pkg::*;
#(
  parameter int unsigned XSR_CYCLES = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cke,
  input  logic [CMD_W-1:0]   cmd,
  input  logic               banks_idle,
  output logic [STATE_W-1:0] pwr_state,
  output logic               illegal,
  output logic               in_recovery,
  output logic               recovery_viol
);
  cke_edge_e  edge_kind;
  cmd_e       cmd_t;
  step_t      step;
  pwr_state_e state_q;

  assign cmd_t = cmd_e'(cmd);

  cke_edge_sampler #(.RESET_LEVEL(1'b1)) u_sampler (
    .clk       (clk),
    .rst_n     (rst_n),
    .cke       (cke),
    .edge_kind (edge_kind)
  );

  pwr_step_decode u_decode (
    .cur        (state_q),
    .edge_kind  (edge_kind),
    .cmd        (cmd_t),
    .banks_idle (banks_idle),
    .step       (step)
  );

  pwr_state_reg u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (step),
    .state_q   (state_q),
    .illegal_q (illegal)
  );

  xsr_quiet_window #(.XSR_CYCLES(XSR_CYCLES)) u_window (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (step.sref_exit),
    .cmd    (cmd_t),
    .active (in_recovery),
    .viol   (recovery_viol)
  );

  assign pwr_state = state_q;
endmodule

// File: rtl/cke_tracker_chk.sv
module cke_tracker_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] pwr_state,
  input logic       illegal,
  input logic       in_recovery,
  input logic       recovery_viol
);
  // R1
  state_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_state <= 3'd4);

  // R7
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (pwr_state == $past(pwr_state)));

  // R4
  apd_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd3 && $past(pwr_state) != 3'd3) |->
      ($past(pwr_state) == 3'd0 || $past(pwr_state) == 3'd1));

  // R5
  sref_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 3'd4 && $past(pwr_state) != 3'd4) |->
      ($past(pwr_state) == 3'd0 || $past(pwr_state) == 3'd1));

  // R8
  window_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_recovery) |-> ($past(pwr_state) == 3'd4 && pwr_state == 3'd0));

  // R9
  viol_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    recovery_viol |-> $past(in_recovery));
endmodule

bind cke_power_tracker cke_tracker_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .pwr_state     (pwr_state),
  .illegal       (illegal),
  .in_recovery   (in_recovery),
  .recovery_viol (recovery_viol)
);

// File: tb/cke_power_tracker_tb_top.sv
`timescale 1ns/1ps
module cke_power_tracker_tb_top;
  localparam int XSR = 200;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cke;
  logic [2:0] cmd;
  logic       banks_idle;
  logic [2:0] pwr_state;
  logic       illegal, in_recovery, recovery_viol;

  int checks = 0;
  int failures = 0;

  // behavioural reference
  int    m_state;
  bit    m_prev;
  int    m_cnt;
  bit    m_ill, m_viol;
  string m_tag;

  always #2.5 clk = ~clk;

  cke_power_tracker #(.XSR_CYCLES(XSR)) dut_i (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .banks_idle(banks_idle),
    .pwr_state(pwr_state), .illegal(illegal), .in_recovery(in_recovery),
    .recovery_viol(recovery_viol)
  );

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_edge(bit c, int cm, bit bi);
    bit quiet = (cm == 0) || (cm == 1);
    bit lowp  = (m_state >= 2);
    int nxt   = m_state;
    bit bad   = 0;
    bit ex    = 0;
    if (m_prev == 0 && c == 0) begin
      m_tag = "R2";
      bad = !lowp;
    end else if (m_prev == 0) begin
      m_tag = "R3";
      if (lowp && quiet) begin
        if (m_state == 3) nxt = 1; else nxt = 0;
        ex = (m_state == 4);
      end else bad = 1;
    end else if (c == 0) begin
      if (lowp) bad = 1;
      else if (quiet) begin m_tag = "R4"; nxt = bi ? 2 : 3; end
      else if (cm == 6 && bi) begin m_tag = "R5"; nxt = 4; end
      else bad = 1;
    end else begin
      m_tag = "R6";
      if (lowp) bad = 1; else nxt = bi ? 0 : 1;
    end
    if (bad) begin m_tag = "R7"; nxt = m_state; end
    m_viol  = (m_cnt > 0) && !quiet;
    m_cnt   = ex ? XSR : ((m_cnt > 0) ? m_cnt - 1 : 0);
    m_ill   = bad;
    m_state = nxt;
    m_prev  = c;
  endtask

  task automatic compare_all();
    chk(pwr_state == 3'(m_state), m_tag, "pwr_state", pwr_state, m_state);
    chk(illegal == m_ill, m_ill ? "R7" : m_tag, "illegal", illegal, m_ill);
    chk(in_recovery == (m_cnt > 0), "R8", "in_recovery", in_recovery, m_cnt > 0);
    chk(recovery_viol == m_viol, "R9", "recovery_viol", recovery_viol, m_viol);
  endtask

  // called at a negedge: drive, pass an edge, model, compare at next negedge
  task automatic cyc(bit c, int cm, bit bi);
    cke = c; cmd = 3'(cm); banks_idle = bi;
    @(posedge clk);
    model_edge(c, cm, bi);
    @(negedge clk);
    compare_all();
  endtask

  task automatic repeat_cyc(int n, bit c, int cm, bit bi);
    for (int i = 0; i < n; i++) cyc(c, cm, bi);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    #(5.0 * 150000);
    failures++;
    $display("FAIL watchdog all-requirements act=timeout exp=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; cke = 1'b1; cmd = 3'd0; banks_idle = 1'b1;
    m_state = 0; m_prev = 1; m_cnt = 0; m_ill = 0; m_viol = 0; m_tag = "R1";
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(pwr_state == 3'd0, "R1", "pwr_state", pwr_state, 0);
    chk(illegal == 1'b0, "R1", "illegal", illegal, 0);
    chk(in_recovery == 1'b0, "R1", "in_recovery", in_recovery, 0);
    chk(recovery_viol == 1'b0, "R1", "recovery_viol", recovery_viol, 0);
    rst_n = 1'b1;

    // R6 normal operation following bank status, assorted commands
    cyc(1, 2, 0); cyc(1, 3, 0); cyc(1, 5, 1); cyc(1, 7, 1); cyc(1, 0, 0);
    // R4 precharge power down, R2 hold with any command, R3 exit
    cyc(1, 0, 1); cyc(0, 1, 1); cyc(0, 2, 0); cyc(0, 6, 1); cyc(1, 0, 1);
    // R4 active power down, R3 exit back to Active
    cyc(1, 2, 0); cyc(0, 0, 0); repeat_cyc(3, 0, 4, 0); cyc(1, 1, 0);
    // R7 illegal cases
    cyc(1, 0, 1); cyc(0, 3, 1);          // high->low with READ
    cyc(0, 0, 1);                        // low/low while Idle
    cyc(1, 0, 1); cyc(0, 6, 0);          // AREF with banks open
    cyc(0, 0, 0); cyc(1, 0, 1); cyc(0, 0, 1); // reach Precharge PD
    cyc(1, 2, 1);                        // exit with ACT
    cyc(1, 0, 1);                        // high/high inside power down
    cyc(0, 0, 1); cyc(1, 0, 1);          // low/high from power down
    // R5 self refresh, R8 window, R9 violation
    cyc(1, 0, 1); cyc(0, 6, 1); repeat_cyc(4, 0, 0, 1); cyc(1, 0, 1);
    repeat_cyc(50, 1, 0, 1);
    cyc(1, 2, 0);                        // violation in window
    repeat_cyc(XSR, 1, 1, 0);            // window runs out
    cyc(1, 3, 0);                        // no violation after window
    // overlap: legal self refresh entry and violation on the same edge
    cyc(1, 0, 1); cyc(0, 6, 1); cyc(0, 0, 1); cyc(1, 0, 1);
    repeat_cyc(10, 1, 0, 1);
    cyc(0, 6, 1);                        // R5 + R9 together
    repeat_cyc(3, 0, 0, 1); cyc(1, 1, 1); // R8 reload on new exit
    repeat_cyc(20, 1, 0, 1);
    cyc(0, 3, 1);                        // R7 + R9 together
    cyc(1, 0, 1);
    repeat_cyc(XSR, 1, 0, 1);
    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      bit c = (r < 80) ? m_prev : !m_prev;
      int cm = (int'($urandom_range(0, 9)) < 7) ? int'($urandom_range(0, 1))
                                                : int'($urandom_range(0, 7));
      cyc(c, cm, 1'($urandom_range(0, 1)));
    end
    summary();
    $finish;
  end
endmodule